// File: doc/BRIEF.md
# Timer Compare Unit with Period Trigger

This block pairs a 16-bit up-counting timer with one compare channel. The timer advances on each clock where the timer-enable input is high. On each such increment the channel compares the current timer value with a 16-bit compare register. A 4-bit mode field in the control register decides what a match does. It can drive the compare output pin high, drive it low, or only raise the channel flag. It can also fire a trigger that clears the timer, so the compare register sets the counting period.

Software configures the block through a byte-wide write port. That port holds the compare value, the control register and the two timer bytes. The channel flag is sticky and is cleared by a one-cycle strobe. A separate overflow flag records ordinary wraps of the timer. A build parameter selects a second channel variant. In that variant, the period trigger also sends a one-cycle conversion-start pulse to an external converter when that converter reports it is enabled. Everything runs in a single clock domain.

Top module: `cmp_event_unit`

## Requirements
- R1: After reset the timer reads 0, the compare pin is low, and the channel flag, the overflow flag and the conversion pulse are all low. The mode field is 0, so compare is disabled.
- R2: In mode 1011 (period trigger), a match loads 0 into the timer instead of incrementing it. With the compare value C, the trigger therefore repeats every C+1 enabled timer clocks.
- R3: The overflow flag is set when normal counting wraps the timer from 0xFFFF to 0x0000. A timer clear caused by the period trigger never sets it. It stays set until `flag_clr[1]` is pulsed.
- R4: In mode 1000 a match drives the compare pin high. In mode 1001 a match drives it low.
- R5: Every enabled mode (1000, 1001, 1010, 1011) sets the channel flag on a match. The flag stays set until a cycle with `flag_clr[0]` high. If a match and a clear fall in the same cycle, the flag is set.
- R6: In mode 1010 a match sets only the channel flag. The compare pin keeps its level.
- R7: A write of zero to bits [5:0] of the control register forces the compare pin low on the next clock. A nonzero control write leaves the pin unchanged.
- R8: With parameter HAS_CONV=1, a period-trigger match while `conv_enabled` is high gives `conv_start` high for exactly one cycle. With `conv_enabled` low there is no pulse, but the timer is still cleared.
- R9: The timer changes only on clocks with `tmr_en` high or with a timer write. A match needs `tmr_en` high.
- R10: Write addresses are 0 for the compare low byte, 1 for the compare high byte, 2 for control, 3 for the timer low byte and 4 for the timer high byte. Control bits [3:0] are the mode, bits [5:4] are stored with no effect, and bits [7:6] are ignored. A timer write takes priority over counting in the same cycle.
- R11: Mode values outside 1000 to 1011 disable compare. A match condition then sets no flag and leaves the pin unchanged, and the timer counts normally.
- R12: All results (pin, flags, conversion pulse, timer value) are registered. They appear on the clock edge that evaluates the stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| tmr_en | input | 1 | Timer increment enable |
| conv_enabled | input | 1 | External converter is enabled |
| flag_clr | input | 2 | Clear strobes: bit 0 channel flag, bit 1 overflow flag |
| tmr_val | output | TW | Current timer value |
| cmp_out | output | 1 | Compare output pin |
| cmp_flag | output | 1 | Sticky channel match flag |
| ovf_flag | output | 1 | Sticky timer overflow flag |
| conv_start | output | 1 | One-cycle conversion-start pulse |

## Verification
Each result is due one clock after its stimulus. A match at timer value V on edge k shows the pin level, the channel flag, the conversion pulse and the cleared timer right after edge k. A register write appears on the edge that samples it. The bench drives inputs on falling edges and samples outputs on the following falling edge, so each check sees exactly one evaluating edge. Period checks under random gating of `tmr_en` count only enabled edges between two conversion pulses and compare that count with C+1.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;
    localparam int CTRL_W = 6;
    localparam int MODE_W = 4;

    localparam logic [ADDR_W-1:0] A_CMP_LO = 3'd0;
    localparam logic [ADDR_W-1:0] A_CMP_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd2;
    localparam logic [ADDR_W-1:0] A_TMR_LO = 3'd3;
    localparam logic [ADDR_W-1:0] A_TMR_HI = 3'd4;

    localparam logic [MODE_W-1:0] MODE_SET  = 4'b1000;
    localparam logic [MODE_W-1:0] MODE_CLR  = 4'b1001;
    localparam logic [MODE_W-1:0] MODE_SWI  = 4'b1010;
    localparam logic [MODE_W-1:0] MODE_TRIG = 4'b1011;
endpackage

// File: rtl/cmp_regs.sv
module cmp_regs
    import cmp_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [BYTE_W-1:0]   wr_data,
    output logic [TW-1:0]       cmp_val,
    output logic [MODE_W-1:0]   mode,
    output logic                ctrl_zero_wr
);
    localparam int HW = TW - BYTE_W;

    typedef struct packed {
        logic [TW-1:0]     cmp;
        logic [CTRL_W-1:0] ctrl;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (wr_addr)
                A_CMP_LO: regs_d.cmp[BYTE_W-1:0] = wr_data;
                A_CMP_HI: regs_d.cmp[TW-1:BYTE_W] = wr_data[HW-1:0];
                A_CTRL:   regs_d.ctrl = wr_data[CTRL_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign cmp_val      = regs_q.cmp;
    assign mode         = regs_q.ctrl[MODE_W-1:0];
    assign ctrl_zero_wr = wr_en && (wr_addr == A_CTRL) && (wr_data[CTRL_W-1:0] == '0);

    AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_CTRL) |=> (mode == $past(wr_data[MODE_W-1:0]))); // R10
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import cmp_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tmr_en,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              trig_clr,
    input  logic              ovf_clr,
    output logic [TW-1:0]     tmr_val,
    output logic              ovf_flag
);
    localparam int HW = TW - BYTE_W;
    localparam logic [TW-1:0] TMAX = '1;

    typedef struct packed {
        logic [TW-1:0] tmr;
        logic          ovf;
    } tmr_t;

    tmr_t st_d, st_q;
    logic wr_any, wrap;

    always_comb begin
        st_d   = st_q;
        wr_any = wr_lo || wr_hi;
        wrap   = tmr_en && !wr_any && !trig_clr && (st_q.tmr == TMAX);
        if (wr_any) begin
            if (wr_lo) st_d.tmr[BYTE_W-1:0] = wr_data;
            if (wr_hi) st_d.tmr[TW-1:BYTE_W] = wr_data[HW-1:0];
        end else if (tmr_en) begin
            if (trig_clr) st_d.tmr = '0;
            else          st_d.tmr = st_q.tmr + TW'(1);
        end
        st_d.ovf = (st_q.ovf && !ovf_clr) || wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tmr_val  = st_q.tmr;
    assign ovf_flag = st_q.ovf;

    AST_NO_OVF_ON_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_clr && !ovf_flag) |=> !ovf_flag); // R3
    AST_TRIG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_clr && tmr_en && !wr_lo && !wr_hi) |=> (tmr_val == '0)); // R2
    AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmr_en && !wr_lo && !wr_hi) |=> $stable(tmr_val)); // R9
    AST_WRAP_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_en && !wr_lo && !wr_hi && !trig_clr && tmr_val == TMAX) |=> ovf_flag); // R3
endmodule

// File: rtl/cmp_action.sv
module cmp_action
    import cmp_pkg::*;
#(
    parameter int TW       = 16,
    parameter bit HAS_CONV = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tmr_en,
    input  logic [TW-1:0]     tmr_val,
    input  logic [TW-1:0]     cmp_val,
    input  logic [MODE_W-1:0] mode,
    input  logic              ctrl_zero_wr,
    input  logic              flag_clr,
    input  logic              conv_enabled,
    output logic              trig_clr,
    output logic              pin,
    output logic              flag,
    output logic              conv_start
);
    typedef struct packed {
        logic pin;
        logic flag;
        logic conv;
    } act_t;

    act_t act_d, act_q;
    logic mode_on, match, conv_req;

    assign mode_on  = (mode[MODE_W-1:MODE_W-2] == 2'b10);
    assign match    = tmr_en && mode_on && (tmr_val == cmp_val);
    assign trig_clr = match && (mode == MODE_TRIG);

    generate
        if (HAS_CONV) begin : g_conv
            assign conv_req = trig_clr && conv_enabled;
        end else begin : g_noconv
            assign conv_req = 1'b0;
        end
    endgenerate

    always_comb begin
        act_d = act_q;
        if (ctrl_zero_wr) begin
            act_d.pin = 1'b0;
        end else if (match) begin
            if (mode == MODE_SET)      act_d.pin = 1'b1;
            else if (mode == MODE_CLR) act_d.pin = 1'b0;
        end
        act_d.flag = (act_q.flag && !flag_clr) || match;
        act_d.conv = conv_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= '0;
        else        act_q <= act_d;
    end

    assign pin        = act_q.pin;
    assign flag       = act_q.flag;
    assign conv_start = act_q.conv;

    AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> flag); // R5
    AST_SET_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (match && mode == MODE_SET && !ctrl_zero_wr) |=> pin); // R4
    AST_CLR_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (match && mode == MODE_CLR) |=> !pin); // R4
    AST_SWI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (match && mode == MODE_SWI && !ctrl_zero_wr) |=> $stable(pin)); // R6
    AST_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_zero_wr |=> !pin); // R7
    AST_CONV_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> ($past(conv_enabled) && $past(tmr_en))); // R8
endmodule

// File: rtl/cmp_event_unit.sv
module cmp_event_unit
    import cmp_pkg::*;
#(
    parameter int TW       = 16,
    parameter bit HAS_CONV = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              tmr_en,
    input  logic              conv_enabled,
    input  logic [1:0]        flag_clr,
    output logic [TW-1:0]     tmr_val,
    output logic              cmp_out,
    output logic              cmp_flag,
    output logic              ovf_flag,
    output logic              conv_start
);
    logic [TW-1:0]     cmp_val;
    logic [MODE_W-1:0] mode;
    logic              ctrl_zero_wr, trig_clr, wr_lo, wr_hi;

    assign wr_lo = wr_en && (wr_addr == A_TMR_LO);
    assign wr_hi = wr_en && (wr_addr == A_TMR_HI);

    cmp_regs #(.TW(TW)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cmp_val(cmp_val), .mode(mode),
        .ctrl_zero_wr(ctrl_zero_wr)
    );

    cmp_timer #(.TW(TW)) timer_i (
        .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .wr_lo(wr_lo),
        .wr_hi(wr_hi), .wr_data(wr_data), .trig_clr(trig_clr),
        .ovf_clr(flag_clr[1]), .tmr_val(tmr_val), .ovf_flag(ovf_flag)
    );

    cmp_action #(.TW(TW), .HAS_CONV(HAS_CONV)) action_i (
        .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .tmr_val(tmr_val),
        .cmp_val(cmp_val), .mode(mode), .ctrl_zero_wr(ctrl_zero_wr),
        .flag_clr(flag_clr[0]), .conv_enabled(conv_enabled),
        .trig_clr(trig_clr), .pin(cmp_out), .flag(cmp_flag),
        .conv_start(conv_start)
    );

    AST_RESULT_REG: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmr_en && !wr_en && flag_clr == 2'b00) |=> ($stable(cmp_flag) && $stable(cmp_out))); // R12
endmodule

// File: tb/cmp_event_unit_tb_top.sv
module cmp_event_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        tmr_en = 1'b0;
    logic        conv_enabled = 1'b0;
    logic [1:0]  flag_clr = '0;
    logic [15:0] tmr_val;
    logic        cmp_out, cmp_flag, ovf_flag, conv_start;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    cmp_event_unit #(.TW(16), .HAS_CONV(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tmr_en(tmr_en), .conv_enabled(conv_enabled),
        .flag_clr(flag_clr), .tmr_val(tmr_val), .cmp_out(cmp_out),
        .cmp_flag(cmp_flag), .ovf_flag(ovf_flag), .conv_start(conv_start)
    );

    function automatic int exp_period(int c);
        return c + 1;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_cmp(logic [15:0] v);
        wr(3'd0, v[7:0]); wr(3'd1, v[15:8]);
    endtask

    task automatic set_tmr(logic [15:0] v);
        wr(3'd3, v[7:0]); wr(3'd4, v[15:8]);
    endtask

    task automatic run(int n);
        tmr_en = 1'b1;
        repeat (n) @(negedge clk);
        tmr_en = 1'b0;
    endtask

    task automatic clr(logic [1:0] m);
        flag_clr = m;
        @(negedge clk);
        flag_clr = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog all-reqs act=hung exp=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 tmr", tmr_val, 0);
        chk("R1 pin", cmp_out, 0);
        chk("R1 flag", cmp_flag, 0);
        chk("R1 ovf", ovf_flag, 0);
        chk("R1 conv", conv_start, 0);
        // R1/R9: mode 0 with cmp=0 matching value 0: no flag; counts 5
        run(5);
        chk("R1 disabled flag", cmp_flag, 0);
        chk("R9 count", tmr_val, 5);
        repeat (3) @(negedge clk);
        chk("R9 hold", tmr_val, 5);

        // R11 invalid mode 1100
        set_cmp(16'd10); wr(3'd2, 8'h0C); set_tmr(16'd10);
        run(1);
        chk("R11 flag", cmp_flag, 0);
        chk("R11 pin", cmp_out, 0);
        chk("R11 count", tmr_val, 11);

        // R4 set mode, R12 timing
        wr(3'd2, 8'h08); set_tmr(16'd8);
        run(2);
        chk("R12 pin before match", cmp_out, 0);
        run(1);
        chk("R4 set pin", cmp_out, 1);
        chk("R5 flag", cmp_flag, 1);
        chk("R12 tmr", tmr_val, 11);
        run(3);
        chk("R5 sticky", cmp_flag, 1);
        clr(2'b01);
        chk("R5 cleared", cmp_flag, 0);
        // R5 set wins over clear
        set_tmr(16'd10);
        flag_clr = 2'b01; tmr_en = 1'b1;
        @(negedge clk);
        flag_clr = '0; tmr_en = 1'b0;
        chk("R5 set wins", cmp_flag, 1);

        // R4 clear mode
        clr(2'b01);
        wr(3'd2, 8'h09);
        chk("R7 nonzero keeps pin", cmp_out, 1);
        set_tmr(16'd10);
        run(1);
        chk("R4 clr pin", cmp_out, 0);

        // R6 software-only mode with pin high
        wr(3'd2, 8'h08); set_tmr(16'd10); run(1);
        chk("R4 set again", cmp_out, 1);
        wr(3'd2, 8'h0A); clr(2'b01); set_tmr(16'd10);
        run(1);
        chk("R6 pin held", cmp_out, 1);
        chk("R6 flag", cmp_flag, 1);

        // R7 zero write forces low
        wr(3'd2, 8'h00);
        chk("R7 pin low", cmp_out, 0);
        clr(2'b01);

        // R2/R8 period trigger, bits 5:4 and 7:6 set (R10)
        conv_enabled = 1'b1;
        set_cmp(16'd5); wr(3'd2, 8'hFB); set_tmr(16'd0);
        run(5);
        chk("R2 tmr at cmp", tmr_val, 5);
        chk("R8 no conv yet", conv_start, 0);
        run(1);
        chk("R2 tmr cleared", tmr_val, 0);
        chk("R8 conv pulse", conv_start, 1);
        chk("R10 upper bits ignored", cmp_flag, 1);
        run(1);
        chk("R8 one cycle", conv_start, 0);
        chk("R2 restart", tmr_val, 1);
        chk("R3 no ovf", ovf_flag, 0);

        // R8 converter disabled
        conv_enabled = 1'b0;
        set_tmr(16'd5); run(1);
        chk("R8 gated conv", conv_start, 0);
        chk("R8 still clears", tmr_val, 0);

        // R3 trigger at 0xFFFF
        conv_enabled = 1'b1;
        set_cmp(16'hFFFF); set_tmr(16'hFFFE);
        run(1);
        chk("R3 at max", tmr_val, 16'hFFFF);
        run(1);
        chk("R3 trig wrap tmr", tmr_val, 0);
        chk("R3 trig no ovf", ovf_flag, 0);
        chk("R8 conv at max", conv_start, 1);
        // natural wrap in set mode
        wr(3'd2, 8'h08); set_cmp(16'd100); set_tmr(16'hFFFE);
        run(2);
        chk("R3 natural wrap tmr", tmr_val, 0);
        chk("R3 ovf set", ovf_flag, 1);
        run(2);
        chk("R3 ovf sticky", ovf_flag, 1);
        clr(2'b10);
        chk("R3 ovf cleared", ovf_flag, 0);

        // R10 timer write overrides counting
        wr_en = 1'b1; wr_addr = 3'd3; wr_data = 8'h40; tmr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tmr_en = 1'b0;
        chk("R10 write priority", tmr_val[7:0], 8'h40);

        // Random period checks with gated tmr_en (R2, R9)
        for (int it = 0; it < 20; it++) begin
            int c = 1 + int'($urandom % 60);
            int cnt = 0;
            int got = 0;
            bit seen = 0;
            conv_enabled = 1'b1;
            wr(3'd2, 8'h00);
            set_cmp(c[15:0]); set_tmr(16'd0); wr(3'd2, 8'h0B);
            while (got < 2) begin
                @(negedge clk);
                if (conv_start) begin
                    if (seen) begin
                        chk("R2 random period", cnt, exp_period(c));
                        got++;
                    end
                    seen = 1;
                    cnt  = 0;
                end
                tmr_en = ($urandom % 4) != 0;
                if (tmr_en) cnt++;
            end
            tmr_en = 1'b0;
            chk("R3 random no ovf", ovf_flag, 0);
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule